// File: doc/BRIEF.md
# Warp-Granularity Thread-Block Dispatcher

This block is the per-core admission and launch logic for a GPU compute core. It keeps four resource pools: registers, warp slots, block slots and shared memory. When a thread-block launch request arrives, it first tests whether the whole block fits. If it does, the block is admitted in full. If it does not, as many of its warps as registers and warp slots allow are admitted. Shared memory is always reserved for the whole block. The warps that could not start are parked in a small pending buffer as a contiguous warp-id range.

Admitted warps are announced one per cycle on a launch port, tagged with a hardware block slot id, the software block id and the warp id. Each warp-completion pulse returns that warp's registers and its warp slot at once. The block's shared memory and block slot are returned only when its last warp completes. Freed resources let pending warps launch, lowest pending entry first, ahead of any new block.

Top module: `warp_dispatch`

## Requirements
- R1: After reset, all pools are at capacity, `launchValid` is low, and `reqReady` is high for any request that fits (warp count at least 1).
- R2: A block whose full register need (warp count × registers per warp) and warp count both fit is admitted whole. Its warps launch on consecutive cycles with warp ids 0 up to count−1.
- R3: A block that does not fit whole admits k = min(count, free warp slots, floor(free registers / registers per warp)) warps. Only warps 0 to k−1 launch before any completion.
- R4: A completion pulse on a block slot returns that block's per-warp registers and one warp slot in the cycle it is seen. A pending warp that then fits launches without waiting for its sibling warps to finish.
- R5: Shared memory is reserved for the whole block at admission. It stays reserved while any warp of the block has not completed, even when other warps of that block have finished.
- R6: While a pending warp can launch, no new block is accepted. A waiting request is accepted only after the pending warps that fit have launched.
- R7: At most 8 blocks are resident. A block slot is reused only after every warp of its block has completed. No two live blocks share a slot id.
- R8: A request is accepted only when a block slot is free, a pending entry is free, its shared memory fits, and at least one warp fits.
- R9: Every warp of every admitted block launches exactly once, in ascending warp-id order within the block.
- R10: Free registers, free warp slots and free shared memory never exceed capacity and never wrap below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Block launch request present |
| reqReady | output | 1 | Request is accepted on this edge if valid |
| reqSwId | input | 26 | Software block id |
| reqWarpCnt | input | 6 | Warps in the block, 1 to 32 |
| reqRegsPerWarp | input | 16 | Registers needed per warp |
| reqSmem | input | 16 | Shared-memory bytes for the block |
| doneValid | input | 1 | One warp has completed |
| doneHwId | input | 3 | Block slot of the completed warp |
| launchValid | output | 1 | A warp launches this cycle |
| launchHwId | output | 3 | Block slot of the launched warp |
| launchSwId | output | 26 | Software block id of the launched warp |
| launchWarpId | output | 5 | Warp id within the block |

## Verification
The assertions assume a well-formed environment. Requests keep their warp count between 1 and 32 and never ask for more registers or shared memory than the core holds. A completion pulse names only a live block slot and only for a warp that has already launched. The bench meets these rules in three ways. It issues completions only for warps it has seen on the launch port, and never more of them than a block has warps. It chooses register and shared-memory sizes that fit the pools, including the zero-register case. It releases each request only after observing acceptance.

// File: rtl/warp_dispatch_pkg.sv
package warp_dispatch_pkg;

  // Decisions handed from control to datapath for one cycle
  typedef struct packed {
    logic burstStep;     // issue next warp of the freshly admitted range
    logic pendLaunch;    // issue one warp from the selected pending entry
    logic admit;         // accept the request at the block edge
    logic admitPartial;  // accepted block leaves warps behind in pending
  } dispStrobe_t;

endpackage

// File: rtl/warp_dispatch_ctrl.sv
module warp_dispatch_ctrl
  import warp_dispatch_pkg::*;
#(
  parameter int NUM_SLOTS     = 8,
  parameter int WARP_SLOTS    = 48,
  parameter int MAX_BLK_WARPS = 32,
  parameter int REG_CAP       = 32768,
  parameter int SMEM_CAP      = 49152,
  parameter int PEND_DEPTH    = 4
) (
  input  logic                 reqValid,
  input  logic [CNT_W-1:0]     reqWarpCnt,
  input  logic [REG_W-1:0]     reqRegsPerWarp,
  input  logic [SMEM_W-1:0]    reqSmem,
  input  logic [REG_W-1:0]     freeRegs,
  input  logic [WSLOT_W-1:0]   freeWarps,
  input  logic [SMEM_W-1:0]    freeSmem,
  input  logic [NUM_SLOTS-1:0] slotBusy,
  input  logic [PEND_DEPTH-1:0] pendValid,
  input  logic [REG_W-1:0]     pendRpw [PEND_DEPTH],
  input  logic                 burstBusy,
  output dispStrobe_t          strb,
  output logic [PIDX_W-1:0]    pendIdx,
  output logic [PIDX_W-1:0]    pendFreeIdx,
  output logic [HW_W-1:0]      admitHw,
  output logic [CNT_W-1:0]     admitCnt,
  output logic                 reqReady
);
  localparam int HW_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int CNT_W   = $clog2(MAX_BLK_WARPS + 1);
  localparam int WSLOT_W = $clog2(WARP_SLOTS + 1);
  localparam int REG_W   = $clog2(REG_CAP + 1);
  localparam int SMEM_W  = $clog2(SMEM_CAP + 1);
  localparam int PIDX_W  = (PEND_DEPTH > 1) ? $clog2(PEND_DEPTH) : 1;

  logic pendAny, pendHole, slotHole, pendFits, fullFits, smemFits;
  logic [CNT_W-1:0] partCnt;

  // lowest valid pending entry, lowest empty pending entry, lowest free slot
  always_comb begin
    pendIdx     = '0;
    pendAny     = 1'b0;
    pendFreeIdx = '0;
    pendHole    = 1'b0;
    for (int e = PEND_DEPTH - 1; e >= 0; e--) begin
      if (pendValid[e]) begin
        pendIdx = PIDX_W'(e);
        pendAny = 1'b1;
      end else begin
        pendFreeIdx = PIDX_W'(e);
        pendHole    = 1'b1;
      end
    end
    admitHw  = '0;
    slotHole = 1'b0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (!slotBusy[s]) begin
        admitHw  = HW_W'(s);
        slotHole = 1'b1;
      end
    end
  end

  assign pendFits = (pendRpw[pendIdx] <= freeRegs) && (freeWarps != '0);

  // block-level check: every warp of the request fits at once
  assign fullFits = (32'(reqWarpCnt) * 32'(reqRegsPerWarp) <= 32'(freeRegs)) &&
                    (32'(reqWarpCnt) <= 32'(freeWarps));
  assign smemFits = reqSmem <= freeSmem;

  // warp-level check: largest prefix of warps that fits
  always_comb begin
    partCnt = '0;
    for (int i = 1; i <= MAX_BLK_WARPS; i++) begin
      if ((32'(i) <= 32'(reqWarpCnt)) && (32'(i) <= 32'(freeWarps)) &&
          (32'(i) * 32'(reqRegsPerWarp) <= 32'(freeRegs)))
        partCnt = CNT_W'(i);
    end
  end

  assign admitCnt = fullFits ? reqWarpCnt : partCnt;

  always_comb begin
    strb.burstStep    = burstBusy;
    strb.pendLaunch   = !burstBusy && pendAny && pendFits;
    reqReady          = !burstBusy && !(pendAny && pendFits) && slotHole &&
                        pendHole && smemFits && (admitCnt != '0);
    strb.admit        = reqValid && reqReady;
    strb.admitPartial = strb.admit && (admitCnt != reqWarpCnt);
  end

endmodule

// File: rtl/warp_dispatch_dp.sv
module warp_dispatch_dp
  import warp_dispatch_pkg::*;
#(
  parameter int NUM_SLOTS     = 8,
  parameter int WARP_SLOTS    = 48,
  parameter int MAX_BLK_WARPS = 32,
  parameter int REG_CAP       = 32768,
  parameter int SMEM_CAP      = 49152,
  parameter int PEND_DEPTH    = 4,
  parameter int SWID_W        = 26
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dispStrobe_t           strb,
  input  logic [PIDX_W-1:0]     pendIdx,
  input  logic [PIDX_W-1:0]     pendFreeIdx,
  input  logic [HW_W-1:0]       admitHw,
  input  logic [CNT_W-1:0]      admitCnt,
  input  logic [SWID_W-1:0]     reqSwId,
  input  logic [CNT_W-1:0]      reqWarpCnt,
  input  logic [REG_W-1:0]      reqRegsPerWarp,
  input  logic [SMEM_W-1:0]     reqSmem,
  input  logic                  doneValid,
  input  logic [HW_W-1:0]       doneHwId,
  output logic [REG_W-1:0]      freeRegs,
  output logic [WSLOT_W-1:0]    freeWarps,
  output logic [SMEM_W-1:0]     freeSmem,
  output logic [NUM_SLOTS-1:0]  slotBusy,
  output logic [PEND_DEPTH-1:0] pendValid,
  output logic [REG_W-1:0]      pendRpw [PEND_DEPTH],
  output logic                  burstBusy,
  output logic                  launchValid,
  output logic [HW_W-1:0]       launchHwId,
  output logic [SWID_W-1:0]     launchSwId,
  output logic [WARP_W-1:0]     launchWarpId
);
  localparam int HW_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int CNT_W   = $clog2(MAX_BLK_WARPS + 1);
  localparam int WARP_W  = (MAX_BLK_WARPS > 1) ? $clog2(MAX_BLK_WARPS) : 1;
  localparam int WSLOT_W = $clog2(WARP_SLOTS + 1);
  localparam int REG_W   = $clog2(REG_CAP + 1);
  localparam int SMEM_W  = $clog2(SMEM_CAP + 1);
  localparam int PIDX_W  = (PEND_DEPTH > 1) ? $clog2(PEND_DEPTH) : 1;

  // per-slot block table
  logic [SWID_W-1:0] slotSw   [NUM_SLOTS];
  logic [REG_W-1:0]  slotRpw  [NUM_SLOTS];
  logic [SMEM_W-1:0] slotSmem [NUM_SLOTS];
  logic [CNT_W-1:0]  slotLeft [NUM_SLOTS];
  // pending ranges
  logic [HW_W-1:0]   pendHw    [PEND_DEPTH];
  logic [WARP_W-1:0] pendStart [PEND_DEPTH];
  logic [WARP_W-1:0] pendEnd   [PEND_DEPTH];
  // range admitted on the last acceptance, still being announced
  logic [HW_W-1:0]   burstHw;
  logic [WARP_W-1:0] burstNext, burstEnd;

  logic [31:0] regsAlloc, regsRel, warpsAlloc, warpsRel, smemAlloc, smemRel;
  logic        lastDone;
  logic [HW_W-1:0]   issueHw;
  logic [WARP_W-1:0] issueWarp;

  for (genvar e = 0; e < PEND_DEPTH; e++) begin : g_pendRpw
    assign pendRpw[e] = slotRpw[pendHw[e]];
  end

  always_comb begin
    lastDone   = doneValid && (slotLeft[doneHwId] == CNT_W'(1));
    regsRel    = doneValid ? 32'(slotRpw[doneHwId]) : 32'd0;
    warpsRel   = doneValid ? 32'd1 : 32'd0;
    smemRel    = lastDone ? 32'(slotSmem[doneHwId]) : 32'd0;
    regsAlloc  = 32'd0;
    warpsAlloc = 32'd0;
    smemAlloc  = 32'd0;
    if (strb.pendLaunch) begin
      regsAlloc  = 32'(pendRpw[pendIdx]);
      warpsAlloc = 32'd1;
    end else if (strb.admit) begin
      regsAlloc  = 32'(admitCnt) * 32'(reqRegsPerWarp);
      warpsAlloc = 32'(admitCnt);
      smemAlloc  = 32'(reqSmem);
    end
    issueHw   = strb.burstStep ? burstHw : pendHw[pendIdx];
    issueWarp = strb.burstStep ? burstNext : pendStart[pendIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freeRegs     <= REG_W'(REG_CAP);
      freeWarps    <= WSLOT_W'(WARP_SLOTS);
      freeSmem     <= SMEM_W'(SMEM_CAP);
      slotBusy     <= '0;
      pendValid    <= '0;
      burstBusy    <= 1'b0;
      burstHw      <= '0;
      burstNext    <= '0;
      burstEnd     <= '0;
      launchValid  <= 1'b0;
      launchHwId   <= '0;
      launchSwId   <= '0;
      launchWarpId <= '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        slotSw[s]   <= '0;
        slotRpw[s]  <= '0;
        slotSmem[s] <= '0;
        slotLeft[s] <= '0;
      end
      for (int e = 0; e < PEND_DEPTH; e++) begin
        pendHw[e]    <= '0;
        pendStart[e] <= '0;
        pendEnd[e]   <= '0;
      end
    end else begin
      freeRegs  <= REG_W'(32'(freeRegs) + regsRel - regsAlloc);
      freeWarps <= WSLOT_W'(32'(freeWarps) + warpsRel - warpsAlloc);
      freeSmem  <= SMEM_W'(32'(freeSmem) + smemRel - smemAlloc);

      if (doneValid) begin
        slotLeft[doneHwId] <= slotLeft[doneHwId] - CNT_W'(1);
        if (lastDone) slotBusy[doneHwId] <= 1'b0;
      end
      if (strb.admit) begin
        slotBusy[admitHw] <= 1'b1;
        slotSw[admitHw]   <= reqSwId;
        slotRpw[admitHw]  <= reqRegsPerWarp;
        slotSmem[admitHw] <= reqSmem;
        slotLeft[admitHw] <= reqWarpCnt;
      end

      if (strb.pendLaunch) begin
        if (pendStart[pendIdx] == pendEnd[pendIdx]) pendValid[pendIdx] <= 1'b0;
        else pendStart[pendIdx] <= pendStart[pendIdx] + WARP_W'(1);
      end
      if (strb.admitPartial) begin
        pendValid[pendFreeIdx] <= 1'b1;
        pendHw[pendFreeIdx]    <= admitHw;
        pendStart[pendFreeIdx] <= WARP_W'(admitCnt);
        pendEnd[pendFreeIdx]   <= WARP_W'(reqWarpCnt - CNT_W'(1));
      end

      if (strb.burstStep) begin
        if (burstNext == burstEnd) burstBusy <= 1'b0;
        else burstNext <= burstNext + WARP_W'(1);
      end else if (strb.admit) begin
        burstBusy <= 1'b1;
        burstHw   <= admitHw;
        burstNext <= '0;
        burstEnd  <= WARP_W'(admitCnt - CNT_W'(1));
      end

      launchValid <= strb.burstStep || strb.pendLaunch;
      if (strb.burstStep || strb.pendLaunch) begin
        launchHwId   <= issueHw;
        launchSwId   <= slotSw[issueHw];
        launchWarpId <= issueWarp;
      end
    end
  end

  AST_REG_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    freeRegs <= REG_W'(REG_CAP)); // R10
  AST_WARP_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    freeWarps <= WSLOT_W'(WARP_SLOTS)); // R10
  AST_SMEM_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    freeSmem <= SMEM_W'(SMEM_CAP)); // R10
  AST_DONE_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> slotBusy[doneHwId]); // R7
  AST_ADMIT_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    strb.admit |-> !slotBusy[admitHw]); // R7
  AST_BURST_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (burstBusy && burstNext != burstEnd) |=>
      (burstBusy && burstNext == WARP_W'($past(burstNext) + 1'b1))); // R2
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.burstStep, strb.pendLaunch, strb.admit})); // R6
  AST_SLOT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && slotLeft[doneHwId] > CNT_W'(1)) |=> slotBusy[$past(doneHwId)]); // R5
  AST_PEND_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strb.pendLaunch |-> (pendStart[pendIdx] <= pendEnd[pendIdx])); // R9

endmodule

// File: rtl/warp_dispatch.sv
module warp_dispatch
  import warp_dispatch_pkg::*;
#(
  parameter int NUM_SLOTS     = 8,
  parameter int WARP_SLOTS    = 48,
  parameter int MAX_BLK_WARPS = 32,
  parameter int REG_CAP       = 32768,
  parameter int SMEM_CAP      = 49152,
  parameter int PEND_DEPTH    = 4,
  parameter int SWID_W        = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [SWID_W-1:0] reqSwId,
  input  logic [CNT_W-1:0]  reqWarpCnt,
  input  logic [REG_W-1:0]  reqRegsPerWarp,
  input  logic [SMEM_W-1:0] reqSmem,
  input  logic              doneValid,
  input  logic [HW_W-1:0]   doneHwId,
  output logic              launchValid,
  output logic [HW_W-1:0]   launchHwId,
  output logic [SWID_W-1:0] launchSwId,
  output logic [WARP_W-1:0] launchWarpId
);
  localparam int HW_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int CNT_W   = $clog2(MAX_BLK_WARPS + 1);
  localparam int WARP_W  = (MAX_BLK_WARPS > 1) ? $clog2(MAX_BLK_WARPS) : 1;
  localparam int WSLOT_W = $clog2(WARP_SLOTS + 1);
  localparam int REG_W   = $clog2(REG_CAP + 1);
  localparam int SMEM_W  = $clog2(SMEM_CAP + 1);
  localparam int PIDX_W  = (PEND_DEPTH > 1) ? $clog2(PEND_DEPTH) : 1;

  dispStrobe_t           strb;
  logic [PIDX_W-1:0]     pendIdx, pendFreeIdx;
  logic [HW_W-1:0]       admitHw;
  logic [CNT_W-1:0]      admitCnt;
  logic [REG_W-1:0]      freeRegs;
  logic [WSLOT_W-1:0]    freeWarps;
  logic [SMEM_W-1:0]     freeSmem;
  logic [NUM_SLOTS-1:0]  slotBusy;
  logic [PEND_DEPTH-1:0] pendValid;
  logic [REG_W-1:0]      pendRpw [PEND_DEPTH];
  logic                  burstBusy;

  warp_dispatch_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .WARP_SLOTS(WARP_SLOTS), .MAX_BLK_WARPS(MAX_BLK_WARPS),
    .REG_CAP(REG_CAP), .SMEM_CAP(SMEM_CAP), .PEND_DEPTH(PEND_DEPTH)
  ) ctrl_i (
    .reqValid(reqValid), .reqWarpCnt(reqWarpCnt), .reqRegsPerWarp(reqRegsPerWarp),
    .reqSmem(reqSmem), .freeRegs(freeRegs), .freeWarps(freeWarps), .freeSmem(freeSmem),
    .slotBusy(slotBusy), .pendValid(pendValid), .pendRpw(pendRpw), .burstBusy(burstBusy),
    .strb(strb), .pendIdx(pendIdx), .pendFreeIdx(pendFreeIdx), .admitHw(admitHw),
    .admitCnt(admitCnt), .reqReady(reqReady)
  );

  warp_dispatch_dp #(
    .NUM_SLOTS(NUM_SLOTS), .WARP_SLOTS(WARP_SLOTS), .MAX_BLK_WARPS(MAX_BLK_WARPS),
    .REG_CAP(REG_CAP), .SMEM_CAP(SMEM_CAP), .PEND_DEPTH(PEND_DEPTH), .SWID_W(SWID_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .pendIdx(pendIdx), .pendFreeIdx(pendFreeIdx),
    .admitHw(admitHw), .admitCnt(admitCnt), .reqSwId(reqSwId), .reqWarpCnt(reqWarpCnt),
    .reqRegsPerWarp(reqRegsPerWarp), .reqSmem(reqSmem), .doneValid(doneValid),
    .doneHwId(doneHwId), .freeRegs(freeRegs), .freeWarps(freeWarps), .freeSmem(freeSmem),
    .slotBusy(slotBusy), .pendValid(pendValid), .pendRpw(pendRpw), .burstBusy(burstBusy),
    .launchValid(launchValid), .launchHwId(launchHwId), .launchSwId(launchSwId),
    .launchWarpId(launchWarpId)
  );

endmodule

// File: tb/warp_dispatch_tb_top.sv
module warp_dispatch_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [25:0] reqSwId = '0;
  logic [5:0]  reqWarpCnt = 6'd1;
  logic [15:0] reqRegsPerWarp = '0;
  logic [15:0] reqSmem = '0;
  logic        doneValid = 1'b0;
  logic [2:0]  doneHwId = '0;
  logic        launchValid;
  logic [2:0]  launchHwId;
  logic [25:0] launchSwId;
  logic [4:0]  launchWarpId;

  warp_dispatch dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqSwId(reqSwId),
    .reqWarpCnt(reqWarpCnt), .reqRegsPerWarp(reqRegsPerWarp), .reqSmem(reqSmem),
    .doneValid(doneValid), .doneHwId(doneHwId), .launchValid(launchValid),
    .launchHwId(launchHwId), .launchSwId(launchSwId), .launchWarpId(launchWarpId)
  );

  always #2 clk = ~clk; // 250 MHz

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int expQ[$];           // expected launches, sw*64 + warp
  int hwOf[int];
  int cntOf[int];
  int launched[int];
  int doneCnt[int];
  int firstCyc[int];
  int lastCyc[int];
  bit hwBusy[8];
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000 && !finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // monitor: pops the scoreboard on each launch
  always @(negedge clk) begin
    if (rstN && launchValid) begin
      automatic int sw = int'(launchSwId);
      automatic int w  = int'(launchWarpId);
      if (expQ.size() == 0) begin
        chk(1'b0, "R9 unexpected launch", sw * 64 + w, -1);
      end else begin
        automatic int e = expQ.pop_front();
        chk(e == sw * 64 + w, "R9 launch order", sw * 64 + w, e);
      end
      if (w == 0) begin
        chk(!hwBusy[launchHwId], "R7 slot id unique", int'(hwBusy[launchHwId]), 0);
        hwBusy[launchHwId] = 1'b1;
        hwOf[sw] = int'(launchHwId);
        firstCyc[sw] = cyc;
      end
      if (!launched.exists(sw)) launched[sw] = 0;
      launched[sw] = launched[sw] + 1;
      lastCyc[sw] = cyc;
    end
  end

  task automatic pushExp(input int sw, input int lo, input int hi);
    for (int w = lo; w <= hi; w++) expQ.push_back(sw * 64 + w);
  endtask

  task automatic issue(input int sw, input int cnt, input int rpw, input int smem);
    @(negedge clk);
    reqSwId = 26'(sw);
    reqWarpCnt = 6'(cnt);
    reqRegsPerWarp = 16'(rpw);
    reqSmem = 16'(smem);
    reqValid = 1'b1;
    cntOf[sw] = cnt;
    doneCnt[sw] = 0;
    launched[sw] = 0;
  endtask

  task automatic waitAccept(input string req);
    bit got = 1'b0;
    for (int i = 0; i < 200 && !got; i++) begin
      if (reqReady) begin
        @(posedge clk);
        got = 1'b1;
      end
      @(negedge clk);
    end
    reqValid = 1'b0;
    chk(got, req, int'(got), 1);
  endtask

  task automatic complete(input int sw);
    @(negedge clk);
    doneValid = 1'b1;
    doneHwId = 3'(hwOf[sw]);
    @(negedge clk);
    doneValid = 1'b0;
    doneCnt[sw] = doneCnt[sw] + 1;
    if (doneCnt[sw] == cntOf[sw]) hwBusy[hwOf[sw]] = 1'b0;
  endtask

  // waits n cycles, returns 1 if reqReady stayed low
  task automatic idleNoReady(input int n, output bit quiet);
    quiet = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (reqReady) quiet = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    bit quiet;
    int hw63;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1 ready after reset", int'(reqReady), 1);
    chk(launchValid == 1'b0, "R1 no launch after reset", int'(launchValid), 0);

    // R2: whole block fits
    issue(10, 4, 1024, 4096);
    pushExp(10, 0, 3);
    waitAccept("R2 accept");
    idle(8);
    chk(launched[10] == 4, "R2 warps launched", launched[10], 4);
    chk(lastCyc[10] - firstCyc[10] == 3, "R2 consecutive", lastCyc[10] - firstCyc[10], 3);
    for (int i = 0; i < 4; i++) complete(10);
    idle(3);

    // R3: partial admission, 16 of 20 warps fit the register pool
    issue(20, 20, 2048, 1024);
    pushExp(20, 0, 15);
    waitAccept("R3 accept");
    idle(25);
    chk(launched[20] == 16, "R3 partial warps", launched[20], 16);

    // R8: no register left for even one warp
    issue(30, 1, 64, 64);
    idleNoReady(2, quiet);
    chk(quiet, "R8 refuse when no warp fits", int'(!quiet), 0);

    // R4 / R6: each completion releases one pending warp, new block waits
    pushExp(20, 16, 19);
    complete(20);
    idleNoReady(4, quiet);
    chk(launched[20] == 17, "R4 early release launches pending", launched[20], 17);
    chk(quiet, "R6 pending before new block", int'(!quiet), 0);
    for (int i = 0; i < 3; i++) begin
      complete(20);
      idleNoReady(3, quiet);
      chk(quiet, "R6 pending before new block", int'(!quiet), 0);
    end
    chk(launched[20] == 20, "R6 pending drained", launched[20], 20);
    pushExp(30, 0, 0);
    complete(20);
    waitAccept("R6 accept after drain");
    idle(4);
    chk(launched[30] == 1, "R6 new block launched", launched[30], 1);
    for (int i = 0; i < 15; i++) complete(20);
    complete(30);
    idle(3);

    // R5: shared memory held until the last warp completes
    issue(40, 4, 16384, 40000);
    pushExp(40, 0, 1);
    waitAccept("R5 accept big block");
    idle(5);
    chk(launched[40] == 2, "R3 two warps fit", launched[40], 2);
    issue(50, 1, 0, 16000);
    pushExp(40, 2, 2);
    complete(40);
    idle(3);
    pushExp(40, 3, 3);
    complete(40);
    idle(3);
    chk(launched[40] == 4, "R4 pending warps launched", launched[40], 4);
    complete(40);
    idleNoReady(3, quiet);
    chk(quiet, "R5 smem held while a warp remains", int'(!quiet), 0);
    pushExp(50, 0, 0);
    complete(40);
    waitAccept("R5 accept after last warp");
    idle(4);
    chk(launched[50] == 1, "R5 waiting block launched", launched[50], 1);
    complete(50);
    idle(3);

    // R7: eight resident blocks, slot reuse
    for (int i = 0; i < 8; i++) begin
      issue(60 + i, 1, 0, 0);
      pushExp(60 + i, 0, 0);
      waitAccept("R7 accept resident block");
      idle(3);
    end
    issue(70, 1, 0, 0);
    idleNoReady(3, quiet);
    chk(quiet, "R7 ninth block refused", int'(!quiet), 0);
    hw63 = hwOf[63];
    pushExp(70, 0, 0);
    complete(63);
    waitAccept("R7 accept after slot freed");
    idle(4);
    chk(hwOf[70] == hw63, "R7 freed slot reused", hwOf[70], hw63);
    for (int i = 0; i < 8; i++) if (i != 3) complete(60 + i);
    complete(70);
    idle(5);

    chk(expQ.size() == 0, "R9 all expected warps launched", expQ.size(), 0);
    chk(reqReady == 1'b1, "R10 pools restored", int'(reqReady), 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule